// File: doc/BRIEF.md
# Dual-Port Two-Way Set-Associative Data Cache

This block is a level-one data cache placed between a processor core that issues two independent load/store accesses per cycle and a slower next-level memory. Both CPU ports look up the cache in the same cycle. When every active port hits, both accesses finish in that cycle with no stall. Loads return their word combinationally, and stores commit at the clock edge. A miss holds the CPU interface stalled. The cache then fetches the whole 32-byte line (eight 32-bit words) from the next level and places it in the least recently used way of the indexed set. If that victim line is dirty, it is first streamed back to the next level.

The next level keeps coherence through a snoop port. It presents a line address and holds the request until it gets an acknowledge. The cache answers whether it holds the line and whether the line is modified. A modified line is streamed out beat by beat before the acknowledge. Any line that hits a snoop is invalidated.

Addresses are word addresses. Bits [2:0] select the word within the line. The next `$clog2(SETS)` bits select the set, and the remaining upper bits form the tag. The capacity is set by the `SETS` parameter.

Top module: `dcache_dual2w`

## Requirements
- R1: After reset every line is invalid. With no request pending, `cpu_stall`, `mem_rd_req`, `mem_wvalid` and `snp_ack` are low, and the first access to any address misses.
- R2: A word at address A maps to set A[3 +: SET_W]. Two lines with the same set and different tags can be held at once, one in each way, and both then hit.
- R3: On a miss, `mem_rd_req` is high for exactly one cycle with `mem_addr` equal to the line address (A >> 3). The cache then takes 8 `mem_rvalid` beats in word order 0..7. After the fill, the other seven words of that line hit with no stall.
- R4: When every active port hits, both ports complete in the same cycle with `cpu_stall` low, and each load's `pN_rdata` is valid in that cycle.
- R5: If both ports miss in one cycle, the misses are serviced one at a time, port 0's line first, and `cpu_stall` stays high until both are resident.
- R6: Each set keeps one LRU bit, updated on every hit and every fill. A miss replaces the least recently used way. When both ports hit the same set in one cycle, port 1's way becomes the most recent.
- R7: A store hit writes its word and marks the line dirty. If both ports store to the same word in one cycle, port 1's data is kept. A load in the same cycle as a store to the same word returns the old value.
- R8: Before a dirty victim is replaced, its 8 words are sent with `mem_wvalid` high and `mem_addr` equal to the victim's line address. The fill read request follows in the next cycle.
- R9: A snoop to a dirty line streams the line's 8 words on `snp_wdata` with `snp_wvalid`, then acknowledges with `snp_hit`=1 and `snp_dirty`=1. A snoop to a clean held line acknowledges at once with `snp_hit`=1, `snp_dirty`=0 and no data. A snoop miss acknowledges with `snp_hit`=0. Every snoop hit leaves the line invalid.
- R10: A snoop that arrives while a line fill is in progress is not acknowledged until the fill has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Port 0 access request, held until accepted |
| p0_we | input | 1 | Port 0 store (1) or load (0) |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | 32 | Port 0 store data |
| p0_rdata | output | 32 | Port 0 load data |
| p1_req | input | 1 | Port 1 access request, held until accepted |
| p1_we | input | 1 | Port 1 store (1) or load (0) |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | 32 | Port 1 store data |
| p1_rdata | output | 32 | Port 1 load data |
| cpu_stall | output | 1 | Both ports held; accesses complete on an edge where this is low |
| mem_rd_req | output | 1 | One-cycle line fill request |
| mem_wvalid | output | 1 | Write-back beat valid |
| mem_addr | output | ADDR_W-3 | Line address of the fill or write-back |
| mem_wdata | output | 32 | Write-back beat data |
| mem_rvalid | input | 1 | Fill beat valid |
| mem_rdata | input | 32 | Fill beat data |
| snp_req | input | 1 | Snoop request, held until acknowledged |
| snp_addr | input | ADDR_W-3 | Snooped line address |
| snp_ack | output | 1 | Snoop acknowledge |
| snp_hit | output | 1 | Line held, valid with `snp_ack` |
| snp_dirty | output | 1 | Line modified, valid with `snp_ack` |
| snp_wvalid | output | 1 | Snoop data beat valid |
| snp_wdata | output | 32 | Snoop data beat |

## Verification
The bench builds the cache with `SETS`=4 and `ADDR_W`=10, which gives a 1024-word next-level space. With only four sets, lines 0x00, 0x20 and 0x40 all collide in set 0 after a handful of accesses. That makes LRU victim choice, dirty write-back followed by a re-fetch, and the same-set dual-hit ordering all observable at the ports. The small address space lets the bench keep a full shadow image of the next level. It can therefore check every load, every write-back and every snoop beat word by word.

// File: rtl/dcache_dual2w.sv
module dcache_dual2w #(
  parameter int ADDR_W = 14,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_req,
  input  logic              p0_we,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [31:0]       p0_wdata,
  output logic [31:0]       p0_rdata,
  input  logic              p1_req,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [31:0]       p1_wdata,
  output logic [31:0]       p1_rdata,
  output logic              cpu_stall,
  output logic              mem_rd_req,
  output logic              mem_wvalid,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              snp_req,
  input  logic [ADDR_W-4:0] snp_addr,
  output logic              snp_ack,
  output logic              snp_hit,
  output logic              snp_dirty,
  output logic              snp_wvalid,
  output logic [31:0]       snp_wdata
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - 3 - SET_W;
  localparam int IDX_W = SET_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_WB, S_FREQ, S_FILL, S_SNP} st_t;
  st_t st;

  logic [TAG_W-1:0] tag_q [2][SETS];
  logic [31:0]      dat_q [2][SETS*8];
  logic [SETS-1:0]  vld_q [2];
  logic [SETS-1:0]  dty_q [2];
  logic [SETS-1:0]  lru_q;
  logic [2:0]       cnt;
  logic [SET_W-1:0] f_set;
  logic [TAG_W-1:0] f_tag;
  logic             f_way;

  function automatic logic [1:0] look(input logic [ADDR_W-1:0] a);
    logic [SET_W-1:0] s;
    logic [TAG_W-1:0] t;
    s = a[3 +: SET_W];
    t = a[ADDR_W-1 -: TAG_W];
    look = 2'b00;
    for (int w = 0; w < 2; w++)
      if (vld_q[w][s] && tag_q[w][s] == t) look = {1'b1, w[0]};
  endfunction

  logic [1:0] l0, l1, ls;
  always_comb begin
    l0 = look(p0_addr);
    l1 = look(p1_addr);
    ls = look({snp_addr, 3'b000});
  end

  wire [SET_W-1:0] s0 = p0_addr[3 +: SET_W];
  wire [SET_W-1:0] s1 = p1_addr[3 +: SET_W];
  wire [SET_W-1:0] ss = snp_addr[0 +: SET_W];
  wire miss0 = p0_req && !l0[1];
  wire miss1 = p1_req && !l1[1];
  wire idle  = (st == S_IDLE);
  wire go    = idle && !snp_req && !miss0 && !miss1;
  wire start = idle && !snp_req && (miss0 || miss1);
  wire [SET_W-1:0] ms = miss0 ? s0 : s1;
  wire [TAG_W-1:0] mt = miss0 ? p0_addr[ADDR_W-1 -: TAG_W] : p1_addr[ADDR_W-1 -: TAG_W];
  wire vw = lru_q[ms];
  wire last = (cnt == 3'd7);

  assign cpu_stall  = !go;
  assign p0_rdata   = dat_q[l0[0]][{s0, p0_addr[2:0]}];
  assign p1_rdata   = dat_q[l1[0]][{s1, p1_addr[2:0]}];
  assign mem_rd_req = (st == S_FREQ);
  assign mem_wvalid = (st == S_WB);
  assign mem_addr   = (st == S_WB) ? {tag_q[f_way][f_set], f_set} : {f_tag, f_set};
  assign mem_wdata  = dat_q[f_way][{f_set, cnt}];
  assign snp_hit    = ls[1];
  assign snp_dirty  = ls[1] && dty_q[ls[0]][ss];
  assign snp_wvalid = (st == S_SNP);
  assign snp_wdata  = dat_q[ls[0]][{ss, cnt}];
  assign snp_ack    = snp_req && ((idle && !snp_dirty) || (st == S_SNP && last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      lru_q <= '0;
      vld_q[0] <= '0; vld_q[1] <= '0;
      dty_q[0] <= '0; dty_q[1] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (snp_req) begin
            if (snp_dirty) st <= S_SNP;
            else if (snp_hit) vld_q[ls[0]][ss] <= 1'b0;
          end else if (miss0 || miss1) begin
            st <= (vld_q[vw][ms] && dty_q[vw][ms]) ? S_WB : S_FREQ;
          end else begin
            if (p0_req) begin
              lru_q[s0] <= ~l0[0];
              if (p0_we) dty_q[l0[0]][s0] <= 1'b1;
            end
            if (p1_req) begin
              lru_q[s1] <= ~l1[0];
              if (p1_we) dty_q[l1[0]][s1] <= 1'b1;
            end
          end
        end
        S_WB: begin
          cnt <= cnt + 3'd1;
          if (last) st <= S_FREQ;
        end
        S_FREQ: begin
          cnt <= '0;
          st <= S_FILL;
        end
        S_FILL: if (mem_rvalid) begin
          cnt <= cnt + 3'd1;
          if (last) begin
            st <= S_IDLE;
            vld_q[f_way][f_set] <= 1'b1;
            dty_q[f_way][f_set] <= 1'b0;
            lru_q[f_set] <= ~f_way;
          end
        end
        S_SNP: begin
          cnt <= cnt + 3'd1;
          if (last) begin
            st <= S_IDLE;
            vld_q[ls[0]][ss] <= 1'b0;
            dty_q[ls[0]][ss] <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      f_set <= ms;
      f_tag <= mt;
      f_way <= vw;
    end
    if (go) begin
      if (p0_req && p0_we) dat_q[l0[0]][{s0, p0_addr[2:0]}] <= p0_wdata;
      if (p1_req && p1_we) dat_q[l1[0]][{s1, p1_addr[2:0]}] <= p1_wdata;
    end
    if (st == S_FILL && mem_rvalid) begin
      dat_q[f_way][IDX_W'({f_set, cnt})] <= mem_rdata;
      if (last) tag_q[f_way][f_set] <= f_tag;
    end
  end
endmodule

module dcache_dual2w_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_stall,
  input logic mem_rd_req,
  input logic mem_wvalid,
  input logic snp_req,
  input logic snp_ack,
  input logic snp_wvalid
);
  AST_RDREQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req); // R3
  AST_MEM_HOLDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wvalid) |-> cpu_stall); // R5
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wvalid) |-> mem_rd_req); // R8
  AST_NO_WB_WITH_RDREQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wvalid && mem_rd_req)); // R8
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    snp_ack |-> snp_req); // R9
  AST_SNP_DATA_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wvalid |-> (snp_req && cpu_stall)); // R9
  AST_SNP_NOT_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wvalid |-> !(mem_rd_req || mem_wvalid)); // R10
endmodule

bind dcache_dual2w dcache_dual2w_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_stall(cpu_stall), .mem_rd_req(mem_rd_req),
  .mem_wvalid(mem_wvalid), .snp_req(snp_req), .snp_ack(snp_ack), .snp_wvalid(snp_wvalid)
);

// File: tb/test_dcache_dual2w.sv
module test_dcache_dual2w;
  localparam int AW = 10;
  localparam int NS = 4;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic p0_req = 0, p0_we = 0, p1_req = 0, p1_we = 0;
  logic [AW-1:0] p0_addr = '0, p1_addr = '0;
  logic [31:0] p0_wdata = '0, p1_wdata = '0, p0_rdata, p1_rdata;
  logic cpu_stall, mem_rd_req, mem_wvalid, mem_rvalid;
  logic [AW-4:0] mem_addr, snp_addr = '0;
  logic [31:0] mem_wdata, mem_rdata, snp_wdata;
  logic snp_req = 0, snp_ack, snp_hit, snp_dirty, snp_wvalid;

  dcache_dual2w #(.ADDR_W(AW), .SETS(NS)) i_dcache_dual2w (
    .clk(clk), .rst_n(rst_n),
    .p0_req(p0_req), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .cpu_stall(cpu_stall), .mem_rd_req(mem_rd_req), .mem_wvalid(mem_wvalid), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .snp_req(snp_req), .snp_addr(snp_addr), .snp_ack(snp_ack), .snp_hit(snp_hit),
    .snp_dirty(snp_dirty), .snp_wvalid(snp_wvalid), .snp_wdata(snp_wdata));

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] bmem [1024];
  logic [31:0] refm [1024];
  int evt_k [64];
  int evt_a [64];
  int n_evt = 0;
  int fill_end_cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic log_evt(input int k, input int a);
    if (n_evt < 64) begin evt_k[n_evt] = k; evt_a[n_evt] = a; n_evt++; end
  endtask

  // next-level memory model
  initial begin
    logic [2:0] wb_k, sn_k, fk;
    logic [AW-4:0] fla;
    int beats, dly;
    wb_k = 0; sn_k = 0; beats = 0; dly = 0; fla = '0; fk = 0;
    mem_rvalid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_wvalid) begin
        if (wb_k == 0) log_evt(2, int'(mem_addr));
        bmem[{mem_addr, wb_k}] = mem_wdata;
        wb_k++;
      end else wb_k = 0;
      if (snp_wvalid) begin
        bmem[{snp_addr, sn_k}] = snp_wdata;
        sn_k++;
      end else sn_k = 0;
      mem_rvalid = 0;
      if (beats > 0 && dly == 0) begin
        mem_rvalid = 1;
        mem_rdata = bmem[{fla, fk}];
        fk++;
        beats--;
        if (beats == 0) fill_end_cyc = cyc;
      end else if (dly > 0) dly--;
      if (mem_rd_req) begin
        log_evt(1, int'(mem_addr));
        fla = mem_addr; fk = 0; beats = 8; dly = 1;
      end
    end
  end

  typedef struct packed {
    logic ns;
    logic v0; logic w0; logic [AW-1:0] a0; logic [31:0] d0;
    logic v1; logic w1; logic [AW-1:0] a1; logic [31:0] d1;
  } vec_t;

  localparam logic [31:0] D1 = 32'h1111_0001, D2 = 32'h2222_0002, D3 = 32'h3333_0003;
  localparam logic [31:0] D4 = 32'h4444_0004, D5 = 32'h5555_0005, D6 = 32'h6666_0006;

  localparam vec_t TBL [12] = '{
    '{1'b0, 1'b1,1'b0,10'h000,32'h0, 1'b0,1'b0,10'h000,32'h0},  // R1 R3 cold miss
    '{1'b1, 1'b1,1'b0,10'h001,32'h0, 1'b1,1'b0,10'h007,32'h0},  // R3 R4 same line
    '{1'b0, 1'b1,1'b1,10'h003,D1,    1'b1,1'b0,10'h020,32'h0},  // R7 store, R2 other tag
    '{1'b1, 1'b1,1'b0,10'h003,32'h0, 1'b1,1'b0,10'h021,32'h0},  // R2 both ways, R6 order
    '{1'b0, 1'b1,1'b0,10'h040,32'h0, 1'b0,1'b0,10'h000,32'h0},  // R6 evicts way of line 0
    '{1'b1, 1'b1,1'b0,10'h022,32'h0, 1'b0,1'b0,10'h000,32'h0},  // R6 line 0x20 kept
    '{1'b0, 1'b0,1'b0,10'h000,32'h0, 1'b1,1'b0,10'h003,32'h0},  // R8 written back D1
    '{1'b0, 1'b1,1'b1,10'h008,D2,    1'b1,1'b1,10'h008,D3},     // R7 same word stores
    '{1'b1, 1'b1,1'b0,10'h008,32'h0, 1'b1,1'b1,10'h009,D4},     // R7 port1 wins
    '{1'b1, 1'b1,1'b0,10'h009,32'h0, 1'b1,1'b0,10'h009,32'h0},  // R4 both read one word
    '{1'b0, 1'b1,1'b1,10'h010,D5,    1'b1,1'b0,10'h010,32'h0},  // R7 read sees old
    '{1'b1, 1'b0,1'b0,10'h000,32'h0, 1'b1,1'b0,10'h010,32'h0}   // R7 new value
  };

  task automatic cpu_op(input vec_t v, input string tag);
    int n;
    @(negedge clk);
    p0_req = v.v0; p0_we = v.w0; p0_addr = v.a0; p0_wdata = v.d0;
    p1_req = v.v1; p1_we = v.w1; p1_addr = v.a1; p1_wdata = v.d1;
    #1;
    n = 0;
    while (cpu_stall && n < 500) begin @(negedge clk); #1; n++; end
    if (v.v0 && !v.w0) chk(p0_rdata == refm[v.a0], {tag, " p0 data"}, p0_rdata, refm[v.a0]);
    if (v.v1 && !v.w1) chk(p1_rdata == refm[v.a1], {tag, " p1 data"}, p1_rdata, refm[v.a1]);
    chk((n == 0) == v.ns, {tag, " stall cycles"}, n, v.ns ? 0 : 1);
    if (v.v0 && v.w0) refm[v.a0] = v.d0;
    if (v.v1 && v.w1) refm[v.a1] = v.d1;
    @(posedge clk); #1;
    p0_req = 0; p1_req = 0; p0_we = 0; p1_we = 0;
  endtask

  task automatic snoop(input logic [AW-4:0] la, input bit eh, input bit ed, input int eb, input string tag);
    int beats, n, t0;
    beats = 0; n = 0;
    @(negedge clk);
    snp_req = 1; snp_addr = la; t0 = cyc;
    #1;
    while (!snp_ack && n < 500) begin
      @(negedge clk); #1; n++;
      if (snp_wvalid) begin
        chk(snp_wdata == refm[{la, 3'(beats)}], {tag, " snoop beat"}, snp_wdata, refm[{la, 3'(beats)}]);
        beats++;
      end
    end
    chk(snp_hit == eh, {tag, " snp_hit"}, snp_hit, eh);
    chk(snp_dirty == ed || !eh, {tag, " snp_dirty"}, snp_dirty, ed);
    chk(beats == eb, {tag, " snoop beats"}, beats, eb);
    if (tag == "R10") chk(fill_end_cyc > t0 && fill_end_cyc < cyc, "R10 ack after fill", cyc, fill_end_cyc + 1);
    @(posedge clk); #1;
    snp_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e;
    for (int i = 0; i < 1024; i++) begin
      bmem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0003);
      refm[i] = bmem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!cpu_stall, "R1 stall idle", cpu_stall, 0);
    chk(!mem_rd_req && !mem_wvalid, "R1 no mem traffic", {mem_rd_req, mem_wvalid}, 0);
    chk(!snp_ack, "R1 no snoop ack", snp_ack, 0);

    foreach (TBL[i]) cpu_op(TBL[i], $sformatf("table[%0d]", i));

    // R5: two misses, port 0 line fetched first
    e = n_evt;
    cpu_op('{1'b0, 1'b1,1'b0,10'h0D8,32'h0, 1'b1,1'b0,10'h068,32'h0}, "R5");
    chk(n_evt - e == 2, "R5 two fills", n_evt - e, 2);
    chk(evt_k[e] == 1 && evt_a[e] == 'h1B, "R5 first line", evt_a[e], 'h1B);
    chk(evt_k[e+1] == 1 && evt_a[e+1] == 'h0D, "R5 second line", evt_a[e+1], 'h0D);

    // R8: dirty line 0x01 evicted from set 1
    e = n_evt;
    cpu_op('{1'b0, 1'b1,1'b0,10'h0A8,32'h0, 1'b0,1'b0,10'h000,32'h0}, "R8");
    chk(evt_k[e] == 2 && evt_a[e] == 'h01, "R8 writeback line", evt_a[e], 'h01);
    chk(evt_k[e+1] == 1 && evt_a[e+1] == 'h15, "R8 fill after wb", evt_a[e+1], 'h15);
    chk(bmem[8] == D3 && bmem[9] == D4, "R8 written data", bmem[8], D3);

    // R9: dirty, clean and absent snoops
    cpu_op('{1'b1, 1'b1,1'b1,10'h012,D6, 1'b0,1'b0,10'h000,32'h0}, "R9 make dirty");
    snoop(7'h02, 1'b1, 1'b1, 8, "R9 dirty");
    cpu_op('{1'b0, 1'b1,1'b0,10'h012,32'h0, 1'b0,1'b0,10'h000,32'h0}, "R9 invalidated");
    snoop(7'h02, 1'b1, 1'b0, 0, "R9 clean");
    snoop(7'h3F, 1'b0, 1'b0, 0, "R9 miss");

    // R10: snoop raised during a fill of the same line
    fork
      cpu_op('{1'b0, 1'b1,1'b0,10'h0F0,32'h0, 1'b0,1'b0,10'h000,32'h0}, "R10 cpu");
      begin repeat (3) @(negedge clk); snoop(7'h1E, 1'b1, 1'b0, 0, "R10"); end
    join

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule